// File: doc/BRIEF.md
# Four-Step-Search Block Motion Estimator

This block estimates the motion of one 4x4 block of luma pixels. It compares that block against a 20x20 pixel reference region laid out around it. A pulse on `start` latches the block's position in a 176x144 frame. The block then reads current-block pixels and reference-region pixels from two external synchronous buffers, each with one cycle of read latency. For every candidate displacement it checks, it accumulates a sum of absolute differences (SAD).

The search is adaptive.

- A first coarse pass checks nine displacements spaced by two pixels.
- While the best candidate moves away from the window centre, the window is re-centred on it and another coarse pass runs. This happens at most three times in all.
- A follow-on pass checks only the candidates it has not already seen: five after a corner move, three after an edge move.
- A fine 3x3 pass at one-pixel spacing then settles the final vector.

The block reports the signed vector, its SAD and a one-cycle `done` pulse.

Top module: `fss_motion_est`

## Requirements
- R1: The reference buffer holds a 20x20 region whose top-left corner lies 8 pixels left of and 8 pixels above the block origin, and is addressed as row*20+column. The current buffer is addressed as row*4+column. Each candidate displacement (dx,dy) compares current pixel (r,c) with reference pixel (8+dy+r, 8+dx+c).
- R2: The cost of a candidate is the SAD over its 16 pixel pairs. `min_sad` equals the SAD of the reported vector, up to 4080 for maximally different blocks.
- R3: The first coarse pass evaluates displacement (0,0) first, then the other eight points of {-2,0,+2}x{-2,0,+2} in raster order (rows top to bottom, columns left to right).
- R4: When a coarse pass leaves its best away from the centre, the next coarse pass is centred on that best. It evaluates, in raster order, only those of its nine points that did not lie in the previous window. At most three coarse passes run.
- R5: When a coarse pass keeps its centre as best, or after the third coarse pass, a fine pass evaluates the eight neighbours at offsets {-1,0,+1} around the current best in raster order. The best of the nine gives `mv_x` and `mv_y` (positive x is right, positive y is down).
- R6: A candidate replaces the best so far only when its SAD is strictly smaller, so among equal costs the earliest evaluated wins.
- R7: A candidate whose displaced block would leave the frame is never evaluated and never chosen. The displaced x origin must stay in 0..172 and the y origin in 0..140.
- R8: `done` is high for exactly one cycle per search, and the results are valid in that cycle and held afterwards. A `start` pulse while a search is running is ignored.
- R9: After reset `done` is low and `mv_x`, `mv_y` and `min_sad` are zero.
- R10: Each reported vector component lies within -7..+7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search for the block at the given origin |
| blk_x | input | 8 | Block origin column in the frame |
| blk_y | input | 8 | Block origin row in the frame |
| cur_addr | output | 4 | Current-block buffer read address |
| cur_data | input | 8 | Current-block pixel, one cycle after its address |
| ref_addr | output | 9 | Reference-region buffer read address |
| ref_data | input | 8 | Reference pixel, one cycle after its address |
| done | output | 1 | One-cycle result strobe |
| mv_x | output | 5 | Signed horizontal motion vector |
| mv_y | output | 5 | Signed vertical motion vector |
| min_sad | output | 12 | SAD of the reported vector |

## Verification
A wrong best-point register, or a wrong overlap filter, sends the search down a different path. That shows up as a vector that differs from an independent model at the next `done`, roughly five hundred cycles after `start`. An error in the accumulator or in the address arithmetic shows within the same search as a `min_sad` that no longer equals the SAD of the reported vector. Flat and maximally different images expose tie-break and overflow faults directly. Blocks at opposite frame corners expose a broken frame guard as a vector pointing off the frame.

// File: rtl/fss_motion_est.sv
module fss_motion_est #(
  parameter int PW      = 8,
  parameter int SW      = 12,
  parameter int MW      = 5,
  parameter int BLK     = 4,
  parameter int REGION  = 20,
  parameter int FRAME_W = 176,
  parameter int FRAME_H = 144,
  parameter int XW      = $clog2(FRAME_W),
  parameter int YW      = $clog2(FRAME_H),
  parameter int CAW     = $clog2(BLK*BLK),
  parameter int RAW     = $clog2(REGION*REGION)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [XW-1:0]        blk_x,
  input  logic [YW-1:0]        blk_y,
  output logic [CAW-1:0]       cur_addr,
  input  logic [PW-1:0]        cur_data,
  output logic [RAW-1:0]       ref_addr,
  input  logic [PW-1:0]        ref_data,
  output logic                 done,
  output logic signed [MW-1:0] mv_x,
  output logic signed [MW-1:0] mv_y,
  output logic [SW-1:0]        min_sad
);
  localparam int NPIX   = BLK*BLK;
  localparam int CW     = $clog2(NPIX+1);
  localparam int MARGIN = (REGION-BLK)/2;
  localparam int MAXSAD = NPIX*((1<<PW)-1);

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_EVAL, S_CMP} st_t;
  st_t state;

  logic [XW-1:0] ox;
  logic [YW-1:0] oy;
  logic [3:0] s, bk, kcur;
  logic [1:0] pass;
  logic fin, dv, excl, pt_in;
  logic signed [MW-1:0] cx, cy, mdx, mdy, px, py, bkx, bky;
  logic [SW-1:0] best, acc;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ad;

  always_comb begin
    int ki, kxi, kyi, stp, ra, sx, sy, fx, fy;
    if (pass == 0 && !fin)
      ki = (s == 0) ? 4 : ((s <= 4) ? int'(s) - 1 : int'(s));
    else
      ki = int'(s);
    kxi  = ki % 3 - 1;
    kyi  = ki / 3 - 1;
    stp  = fin ? 1 : 2;
    kcur = 4'(ki);
    px   = MW'(int'(cx) + kxi*stp);
    py   = MW'(int'(cy) + kyi*stp);
    sx   = kxi + int'(mdx);
    sy   = kyi + int'(mdy);
    excl = ((ki == 4) && (pass != 0 || fin)) ||
           ((pass != 0) && !fin && sx >= -1 && sx <= 1 && sy >= -1 && sy <= 1);
    fx    = int'(ox) + int'(px);
    fy    = int'(oy) + int'(py);
    pt_in = fx >= 0 && fx <= FRAME_W-BLK && fy >= 0 && fy <= FRAME_H-BLK;
    ra = (MARGIN + int'(py) + int'(cnt)/BLK)*REGION + MARGIN + int'(px) + int'(cnt)%BLK;
    ref_addr = RAW'(ra);
    bkx = MW'(int'(bk) % 3 - 1);
    bky = MW'(int'(bk) / 3 - 1);
  end

  assign cur_addr = cnt[CAW-1:0];
  assign ad = (cur_data > ref_data) ? cur_data - ref_data : ref_data - cur_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ox <= '0; oy <= '0; s <= '0; bk <= 4'd4; pass <= '0; fin <= 1'b0;
      cx <= '0; cy <= '0; mdx <= '0; mdy <= '0;
      best <= '1; acc <= '0; cnt <= '0; dv <= 1'b0;
      done <= 1'b0; mv_x <= '0; mv_y <= '0; min_sad <= '0;
    end else begin
      done <= 1'b0;
      dv   <= (state == S_EVAL) && (cnt < CW'(NPIX));
      if (dv) acc <= acc + SW'(ad);
      case (state)
        S_IDLE: if (start) begin
          ox <= blk_x; oy <= blk_y;
          cx <= '0; cy <= '0; mdx <= '0; mdy <= '0;
          s <= '0; bk <= 4'd4; pass <= '0; fin <= 1'b0; best <= '1;
          state <= S_PICK;
        end
        S_PICK: begin
          if (s == 4'd9) begin
            if (fin) begin
              done <= 1'b1;
              mv_x <= cx + bkx;
              mv_y <= cy + bky;
              min_sad <= best;
              state <= S_IDLE;
            end else begin
              cx <= cx + (bkx <<< 1);
              cy <= cy + (bky <<< 1);
              s  <= '0;
              bk <= 4'd4;
              if (bk == 4'd4 || pass == 2'd2) fin <= 1'b1;
              else begin
                pass <= pass + 2'd1;
                mdx <= bkx;
                mdy <= bky;
              end
            end
          end else if (excl || !pt_in) begin
            s <= s + 4'd1;
          end else begin
            cnt <= '0;
            acc <= '0;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(NPIX)) state <= S_CMP;
        end
        S_CMP: begin
          if (acc < best) begin
            best <= acc;
            bk <= kcur;
          end
          s <= s + 4'd1;
          state <= S_PICK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ref_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && cnt < CW'(NPIX)) |-> (int'(ref_addr) < REGION*REGION));

  assert_sad_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(min_sad) <= MAXSAD));

  assert_pass_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !fin && s == 4'd9) |-> (pass <= 2'd2));

  assert_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL) |-> pt_in);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mv_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mv_x >= -7 && mv_x <= 7 && mv_y >= -7 && mv_y <= 7));
endmodule

// File: tb/sim_fss_motion_est.sv
module sim_fss_motion_est;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] blk_x = '0, blk_y = '0;
  logic [3:0] cur_addr;
  logic [8:0] ref_addr;
  logic [7:0] cur_data, ref_data;
  logic done;
  logic signed [4:0] mv_x, mv_y;
  logic [11:0] min_sad;

  logic [7:0] refm [400];
  logic [7:0] curm [16];
  int total = 0, bad = 0, gbx, gby, cyc = 0;

  always #2.5 clk = ~clk;

  fss_motion_est u0 (.clk(clk), .rst_n(rst_n), .start(start), .blk_x(blk_x), .blk_y(blk_y),
    .cur_addr(cur_addr), .cur_data(cur_data), .ref_addr(ref_addr), .ref_data(ref_data),
    .done(done), .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad));

  always @(posedge clk) begin
    cur_data <= curm[cur_addr];
    ref_data <= refm[ref_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam int VEC [8][5] = '{
    '{80, 60, 0, 0, 1}, '{80, 60, 2, -2, 0}, '{50, 40, 5, 3, 0}, '{100, 90, -7, 6, 0},
    '{30, 20, 1, -1, 0}, '{120, 70, -3, -5, 0}, '{4, 4, -4, 2, 0}, '{140, 30, 6, 7, 0}};

  function automatic logic [7:0] pix(int mode, int x, int y);
    if (mode == 1) return 8'd50;
    if (mode == 2) return 8'd0;
    return 8'((x*37 + y*91 + x*y*5 + (x^y)*3) & 255);
  endfunction

  task automatic fill(int mode, int bx, int by, int tx, int ty);
    for (int r = 0; r < 20; r++)
      for (int c = 0; c < 20; c++) begin
        int fx = bx - 8 + c, fy = by - 8 + r;
        refm[r*20+c] = (fx >= 0 && fx < 176 && fy >= 0 && fy < 144) ? pix(mode, fx, fy) : 8'hA5;
      end
    for (int i = 0; i < 16; i++)
      curm[i] = (mode == 1) ? 8'd60 : (mode == 2) ? 8'd255 : pix(0, bx+tx+i%4, by+ty+i/4);
    gbx = bx; gby = by;
  endtask

  function automatic int cost(int dx, int dy);
    int sum = 0;
    if (gbx+dx < 0 || gbx+dx > 172 || gby+dy < 0 || gby+dy > 140) return 4095;
    for (int i = 0; i < 16; i++) begin
      int a = refm[(8+dy+i/4)*20 + 8+dx+i%4], b = curm[i];
      sum += (a > b) ? a - b : b - a;
    end
    return sum;
  endfunction

  task automatic model(output int mx, output int my, output int ms);
    int cx = 0, cy = 0, mdx = 0, mdy = 0, bst, bx, by;
    bst = cost(0, 0);
    for (int p = 0; p < 3; p++) begin
      bit moved = 0;
      bx = 0; by = 0;
      for (int k = 0; k < 9; k++) begin
        int kx = k%3 - 1, ky = k/3 - 1, cc;
        if (k == 4) continue;
        if (p > 0 && kx+mdx >= -1 && kx+mdx <= 1 && ky+mdy >= -1 && ky+mdy <= 1) continue;
        cc = cost(cx+2*kx, cy+2*ky);
        if (cc < bst) begin bst = cc; bx = kx; by = ky; moved = 1; end
      end
      cx += 2*bx; cy += 2*by;
      if (!moved) break;
      mdx = bx; mdy = by;
    end
    bx = 0; by = 0;
    for (int k = 0; k < 9; k++) begin
      int cc;
      if (k == 4) continue;
      cc = cost(cx + k%3 - 1, cy + k/3 - 1);
      if (cc < bst) begin bst = cc; bx = k%3 - 1; by = k/3 - 1; end
    end
    mx = cx + bx; my = cy + by; ms = bst;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int rx, ry, rs;
  task automatic run(int bx, int by, bit extra_start);
    int n = 0;
    @(negedge clk);
    blk_x = 8'(bx); blk_y = 8'(by); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (extra_start && n == 40) begin blk_x = 8'd80; blk_y = 8'd60; start = 1'b1; end
      else start = 1'b0;
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done seen", n, 5000);
    rx = mv_x; ry = mv_y; rs = min_sad;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(mv_x == rx && mv_y == ry && min_sad == rs, "R8 results held", mv_x, rx);
  endtask

  task automatic compare_model(string tag);
    int ex, ey, es;
    model(ex, ey, es);
    check(rx == ex, {tag, " R4 R5 mv_x"}, rx, ex);
    check(ry == ey, {tag, " R4 R5 mv_y"}, ry, ey);
    check(rs == es, {tag, " R2 min_sad"}, rs, es);
    check(rs == cost(rx, ry), {tag, " R1 sad of vector"}, rs, cost(rx, ry));
    check(rx >= -7 && rx <= 7 && ry >= -7 && ry <= 7, {tag, " R10 range"}, rx, ry);
  endtask

  initial begin
    for (int i = 0; i < 400; i++) refm[i] = 8'd0;
    for (int i = 0; i < 16; i++) curm[i] = 8'd0;
    #1;
    @(negedge clk); @(negedge clk);
    check(done == 1'b0 && mv_x == 0 && mv_y == 0 && min_sad == 0, "R9 reset outputs", min_sad, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R9 idle after reset", done, 0);

    for (int v = 0; v < 8; v++) begin
      fill(0, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      run(VEC[v][0], VEC[v][1], 1'b0);
      compare_model($sformatf("vec%0d", v));
      if (VEC[v][4] == 1) begin
        check(rx == 0 && ry == 0, "R3 centre match", rx, 0);
        check(rs == 0, "R3 exact sad", rs, 0);
      end
    end

    fill(1, 80, 60, 0, 0);
    run(80, 60, 1'b0);
    check(rx == 0 && ry == 0, "R6 tie keeps centre", rx, 0);
    check(rs == 160, "R6 flat sad", rs, 160);

    fill(2, 80, 60, 0, 0);
    run(80, 60, 1'b0);
    check(rs == 4080, "R2 maximum sad", rs, 4080);
    check(rx == 0 && ry == 0, "R6 max tie centre", rx, 0);

    fill(0, 0, 0, 3, 2);
    run(0, 0, 1'b0);
    compare_model("corner0");
    check(rx >= 0 && ry >= 0, "R7 top-left guard", rx, 0);

    fill(0, 172, 140, -2, -3);
    run(172, 140, 1'b0);
    compare_model("corner1");
    check(rx <= 0 && ry <= 0, "R7 bottom-right guard", rx, 0);

    fill(0, 2, 3, 1, 1);
    run(2, 3, 1'b1);
    compare_model("busy_start R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule